// File: doc/BRIEF.md
# Oversampling UART Receiver

This block recovers asynchronous serial characters from a single line. An external divider supplies a sample tick at sixteen times the bit rate, or at eight times the bit rate when double-speed sampling is selected. The receiver waits for a high-to-low transition on the line and treats it as a start bit. It takes a three-sample majority vote near the centre of each bit. It then collects 5 to 9 data bits, with the least significant bit first, followed by an optional parity bit and a stop bit.

A finished character goes into a one-entry holding register, together with its frame and parity error flags. The register holds the character until the consumer reads it. A frame that finishes while the register is still full is discarded, and the overrun flag is raised. In multi-drop mode, the receiver drops every frame whose address bit is clear. The address bit is the ninth data bit in 9-bit frames and the stop bit in shorter frames. Only frames with the address bit set reach the holding register, so a node can wait for its own address.

Top module: `uart_rx_os`

## Requirements
- R1: After reset, data_o, bit9_o, rx_valid_o, rx_done_o, frame_err_o, par_err_o and ovr_o are all 0.
- R2: With dbl_i=0 each bit lasts 16 tick_i pulses. With dbl_i=1 each bit lasts 8 tick_i pulses. The line is read only on ticks.
- R3: The data length is len_sel_i+5 bits: 0 gives 5 bits, 4 gives 9 bits, and values above 4 give 9 bits. Bits arrive LSB first. Bit 0 appears on data_o[0], and data_o bits above the length read 0.
- R4: In 9-bit frames the ninth data bit appears on bit9_o. In shorter frames bit9_o is 0.
- R5: With par_en_i=1, a parity bit follows the last data bit and precedes the stop bit. par_odd_i=0 selects even parity and par_odd_i=1 selects odd parity. par_err_o is set when the parity check fails. With par_en_i=0, par_err_o is 0.
- R6: Only the first stop bit is examined. If it is voted low, frame_err_o is set for that character, and the frame still ends at that point.
- R7: Each bit is the majority of samples 8, 9 and 10 of the bit (samples 4, 5 and 6 at double speed), where sample 1 is the tick that detected the start. A single disagreeing sample inside the window does not change the bit.
- R8: A start is detected in idle when a high sample is followed by a low sample. If the start bit votes high, the receiver returns to idle and delivers nothing.
- R9: A character is loaded on the clock edge after the tick that carries the stop bit's last vote sample. In that cycle rx_done_o pulses for one cycle. rx_valid_o then stays high until rd_i is asserted.
- R10: If a character completes while rx_valid_o=1 and rd_i is not asserted in the same cycle, ovr_o is set and the held character and flags stay unchanged. rd_i clears both rx_valid_o and ovr_o.
- R11: With mpm_i=1, a frame whose address bit is 0 is dropped: rx_valid_o, the data, the flags and ovr_o do not change. A frame whose address bit is 1 is accepted. The address bit is the ninth data bit in 9-bit frames and the stop bit otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample tick from the baud divider |
| rx_i | input | 1 | Serial line, synchronous to clk_i |
| dbl_i | input | 1 | 1: 8 samples per bit, 0: 16 |
| len_sel_i | input | 3 | Data length minus 5 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1: odd parity, 0: even |
| mpm_i | input | 1 | Multi-drop address filter enable |
| rd_i | input | 1 | Consume held character |
| data_o | output | 8 | Low byte of held character |
| bit9_o | output | 1 | Ninth data bit of held character |
| rx_valid_o | output | 1 | Held character unread |
| rx_done_o | output | 1 | One-cycle load strobe |
| frame_err_o | output | 1 | Stop bit was low |
| par_err_o | output | 1 | Parity mismatch |
| ovr_o | output | 1 | Character dropped, buffer full |

## Verification
The bench uses the default oversampling factors of 16 and 8 and toggles dbl_i, so both vote windows and both bit lengths are covered by the same sequencer. The tick arrives every third clock. This leaves idle cycles between samples, so the one-cycle delivery latency and rd_i collisions can be seen clearly. A behavioural model collects raw samples by absolute position from the start edge and votes on them. Its result is compared with every output on every clock, while directed frames cover lengths 5 to 9, both parity senses, low stop bits, noise samples, start glitches, overrun and address filtering.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned MIN_BITS = 5;
  localparam int unsigned MAX_BITS = 9;
  localparam int unsigned IDX_W    = $clog2(MAX_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int unsigned OS_NORM = 16,
  parameter int unsigned OS_DBL  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic dbl_i,
  input  logic active_i,
  output logic start_o,
  output logic stb_o,
  output logic bit_o
);
  localparam int unsigned CNT_W = $clog2(OS_NORM + 1);
  localparam logic [CNT_W-1:0] MID_N = CNT_W'(OS_NORM / 2 + 1);
  localparam logic [CNT_W-1:0] MID_D = CNT_W'(OS_DBL / 2 + 1);
  localparam logic [CNT_W-1:0] END_N = CNT_W'(OS_NORM);
  localparam logic [CNT_W-1:0] END_D = CNT_W'(OS_DBL);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n, mid, last;
  logic prev_q, v0_q, v1_q;

  assign mid   = dbl_i ? MID_D : MID_N;
  assign last  = dbl_i ? END_D : END_N;
  assign cnt_n = (cnt_q >= last) ? ONE : cnt_q + ONE;

  // falling edge between consecutive samples while idle
  assign start_o = tick_i & ~active_i & prev_q & ~rx_i;
  // third window sample arrives on this tick
  assign stb_o   = tick_i & active_i & (cnt_n == mid + ONE);
  assign bit_o   = (v0_q & v1_q) | (v0_q & rx_i) | (v1_q & rx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= 1'b1;
      v0_q   <= 1'b0;
      v1_q   <= 1'b0;
    end else if (tick_i) begin
      prev_q <= rx_i;
      if (start_o) begin
        cnt_q <= ONE;
      end else if (active_i) begin
        cnt_q <= cnt_n;
        if (cnt_n == mid - ONE) v0_q <= rx_i;
        if (cnt_n == mid)       v1_q <= rx_i;
      end
    end
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                stb_i,
  input  logic                bit_i,
  input  logic [2:0]          len_sel_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  output logic                active_o,
  output logic                frm_done_o,
  output logic [MAX_BITS-1:0] frm_data_o,
  output logic                frm_fe_o,
  output logic                frm_pe_o,
  output logic                frm_addr_o
);
  rx_state_e           state_q;
  logic [IDX_W-1:0]    idx_q, nbits;
  logic [MAX_BITS-1:0] shr_q;
  logic                acc_q, pbit_q;

  localparam logic [IDX_W-1:0] LEN_MAX = IDX_W'(MAX_BITS);
  localparam logic [IDX_W-1:0] LEN_MIN = IDX_W'(MIN_BITS);

  assign nbits    = (len_sel_i > 3'd4) ? LEN_MAX : IDX_W'(len_sel_i) + LEN_MIN;
  assign active_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      shr_q      <= '0;
      acc_q      <= 1'b0;
      pbit_q     <= 1'b0;
      frm_done_o <= 1'b0;
      frm_data_o <= '0;
      frm_fe_o   <= 1'b0;
      frm_pe_o   <= 1'b0;
      frm_addr_o <= 1'b0;
    end else begin
      frm_done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_START;
        ST_START: if (stb_i) begin
          if (bit_i) begin
            state_q <= ST_IDLE;  // glitch
          end else begin
            state_q <= ST_DATA;
            idx_q   <= '0;
            shr_q   <= '0;
            acc_q   <= 1'b0;
            pbit_q  <= 1'b0;
          end
        end
        ST_DATA: if (stb_i) begin
          shr_q[idx_q] <= bit_i;
          acc_q        <= acc_q ^ bit_i;
          if (idx_q == nbits - IDX_W'(1)) state_q <= par_en_i ? ST_PAR : ST_STOP;
          else idx_q <= idx_q + IDX_W'(1);
        end
        ST_PAR: if (stb_i) begin
          pbit_q  <= bit_i;
          state_q <= ST_STOP;
        end
        ST_STOP: if (stb_i) begin
          state_q    <= ST_IDLE;
          frm_done_o <= 1'b1;
          frm_data_o <= shr_q;
          frm_fe_o   <= ~bit_i;
          frm_pe_o   <= par_en_i & (acc_q ^ pbit_q ^ par_odd_i);
          frm_addr_o <= (nbits == LEN_MAX) ? shr_q[MAX_BITS-1] : bit_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> state_q == ST_IDLE);
  // R6
  done_from_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_done_o |-> $past(state_q) == ST_STOP);
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os
  import uart_rx_pkg::*;
#(
  parameter int unsigned OS_NORM = 16,
  parameter int unsigned OS_DBL  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       dbl_i,
  input  logic [2:0] len_sel_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       mpm_i,
  input  logic       rd_i,
  output logic [7:0] data_o,
  output logic       bit9_o,
  output logic       rx_valid_o,
  output logic       rx_done_o,
  output logic       frame_err_o,
  output logic       par_err_o,
  output logic       ovr_o
);
  logic                start, stb, vbit, active;
  logic                frm_done, frm_fe, frm_pe, frm_addr, accept;
  logic [MAX_BITS-1:0] frm_data;

  uart_rx_sampler #(.OS_NORM(OS_NORM), .OS_DBL(OS_DBL)) i_sampler (
    .clk_i, .rst_ni, .tick_i, .rx_i, .dbl_i,
    .active_i(active), .start_o(start), .stb_o(stb), .bit_o(vbit)
  );

  uart_rx_frame i_frame (
    .clk_i, .rst_ni, .start_i(start), .stb_i(stb), .bit_i(vbit),
    .len_sel_i, .par_en_i, .par_odd_i,
    .active_o(active), .frm_done_o(frm_done), .frm_data_o(frm_data),
    .frm_fe_o(frm_fe), .frm_pe_o(frm_pe), .frm_addr_o(frm_addr)
  );

  assign accept = frm_done & (~mpm_i | frm_addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      bit9_o      <= 1'b0;
      rx_valid_o  <= 1'b0;
      rx_done_o   <= 1'b0;
      frame_err_o <= 1'b0;
      par_err_o   <= 1'b0;
      ovr_o       <= 1'b0;
    end else begin
      rx_done_o <= 1'b0;
      if (rd_i) begin
        rx_valid_o <= 1'b0;
        ovr_o      <= 1'b0;
      end
      if (accept) begin
        if (rx_valid_o && !rd_i) begin
          ovr_o <= 1'b1;
        end else begin
          data_o      <= frm_data[7:0];
          bit9_o      <= frm_data[MAX_BITS-1];
          frame_err_o <= frm_fe;
          par_err_o   <= frm_pe;
          rx_valid_o  <= 1'b1;
          rx_done_o   <= 1'b1;
        end
      end
    end
  end

  // R9
  done_after_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> $past(frm_done));
  // R10
  ovr_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> ($stable(data_o) && rx_valid_o));
  // R10
  rd_clears_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !ovr_o);
  // R11
  mpm_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mpm_i && frm_done && !frm_addr && !rd_i) |=> ($stable(rx_valid_o) && !rx_done_o));
endmodule

// File: tb/test_uart_rx_os.sv
module test_uart_rx_os;
  localparam int TICK_DIV = 3;

  logic       clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, rx_i = 1'b1;
  logic       dbl_i = 1'b0, par_en_i = 1'b0, par_odd_i = 1'b0, mpm_i = 1'b0, rd_i = 1'b0;
  logic [2:0] len_sel_i = 3'd3;
  logic [7:0] data_o;
  logic       bit9_o, rx_valid_o, rx_done_o, frame_err_o, par_err_o, ovr_o;

  int checks = 0, fails = 0, done_seen = 0, tdiv = 0;

  uart_rx_os i_uart_rx_os (
    .clk_i, .rst_ni, .tick_i, .rx_i, .dbl_i, .len_sel_i, .par_en_i, .par_odd_i,
    .mpm_i, .rd_i, .data_o, .bit9_o, .rx_valid_o, .rx_done_o, .frame_err_o,
    .par_err_o, .ovr_o
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  always @(negedge clk_i) begin
    tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick_i <= (tdiv == TICK_DIV - 1);
  end

  // ---------------- behavioural reference model ----------------
  logic       m_prev, m_busy, m_pend, m_pfe, m_ppe;
  logic [8:0] m_pdata;
  logic       smp[$];
  logic       bits[$];
  logic [7:0] e_data;
  logic       e_b9, e_valid, e_done, e_fe, e_pe, e_ovr;

  function automatic int m_len();
    return (len_sel_i > 3'd4) ? 9 : int'(len_sel_i) + 5;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_prev = 1'b1; m_busy = 1'b0; m_pend = 1'b0; m_pfe = 1'b0; m_ppe = 1'b0; m_pdata = '0;
      e_data = '0; e_b9 = 1'b0; e_valid = 1'b0; e_done = 1'b0; e_fe = 1'b0; e_pe = 1'b0; e_ovr = 1'b0;
    end else begin
      logic was_valid;
      was_valid = e_valid;
      e_done = 1'b0;
      if (rd_i) begin e_valid = 1'b0; e_ovr = 1'b0; end
      if (m_pend) begin
        if (was_valid && !rd_i) e_ovr = 1'b1;
        else begin
          e_data = m_pdata[7:0]; e_b9 = m_pdata[8]; e_fe = m_pfe; e_pe = m_ppe;
          e_valid = 1'b1; e_done = 1'b1;
        end
      end
      m_pend = 1'b0;
      if (tick_i) begin
        if (!m_busy) begin
          if (m_prev && !rx_i) begin
            m_busy = 1'b1; smp.delete(); bits.delete(); smp.push_back(rx_i);
          end
        end else begin
          int os, pos, nb, k;
          logic v;
          os = dbl_i ? 8 : 16;
          smp.push_back(rx_i);
          pos = smp.size() - 1;
          nb = m_len();
          if (pos % os == os / 2 + 1) begin
            k = pos / os;
            v = (int'(smp[pos-2]) + int'(smp[pos-1]) + int'(smp[pos])) >= 2;
            if (k == 0 && v) m_busy = 1'b0;
            else if (k > 0 && k <= nb + int'(par_en_i)) bits.push_back(v);
            else if (k == nb + 1 + int'(par_en_i)) begin
              logic x; logic addr;
              m_busy = 1'b0;
              m_pdata = '0; x = 1'b0;
              for (int i = 0; i < nb; i++) begin m_pdata[i] = bits[i]; x ^= bits[i]; end
              if (par_en_i) x ^= bits[nb];
              m_ppe = par_en_i && (x != par_odd_i);
              m_pfe = !v;
              addr  = (nb == 9) ? m_pdata[8] : v;
              m_pend = !mpm_i || addr;
            end
          end
        end
        m_prev = rx_i;
      end
    end
  end

  always @(posedge clk_i) if (rst_ni && rx_done_o) done_seen++;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      checks++;
      if (data_o !== e_data || bit9_o !== e_b9 || rx_valid_o !== e_valid || rx_done_o !== e_done ||
          frame_err_o !== e_fe || par_err_o !== e_pe || ovr_o !== e_ovr) begin
        fails++;
        $display("FAIL model R3/R4/R5/R6/R9/R10 t=%0t data %h/%h b9 %b/%b valid %b/%b done %b/%b fe %b/%b pe %b/%b ovr %b/%b (actual/expected)",
                 $time, data_o, e_data, bit9_o, e_b9, rx_valid_o, e_valid, rx_done_o, e_done,
                 frame_err_o, e_fe, par_err_o, e_pe, ovr_o, e_ovr);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic samp(input logic v);
    rx_i = v;
    @(posedge clk_i iff tick_i);
    @(negedge clk_i);
  endtask

  task automatic send_bit(input logic b, input bit noisy);
    int os = dbl_i ? 8 : 16;
    for (int s = 0; s < os; s++) samp((noisy && s == os / 2 - 1) ? ~b : b);
  endtask

  task automatic frame(input logic [8:0] d, input int nb, input bit bad_par,
                       input logic stop_v, input bit noisy);
    logic p = par_odd_i;
    @(negedge clk_i);
    len_sel_i = 3'(nb - 5);
    send_bit(1'b0, noisy);
    for (int i = 0; i < nb; i++) begin send_bit(d[i], noisy); p ^= d[i]; end
    if (par_en_i) send_bit(p ^ bad_par, noisy);
    send_bit(stop_v, noisy);
    for (int i = 0; i < 2; i++) send_bit(1'b1, 1'b0);
  endtask

  task automatic read();
    @(negedge clk_i); rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check("R1 reset outputs", {data_o, bit9_o, rx_valid_o, rx_done_o, frame_err_o, par_err_o, ovr_o}, 0);

    // R2 R3 R9: 8 data bits, normal speed
    d0 = done_seen;
    frame(9'h0A5, 8, 0, 1'b1, 0);
    check("R3 data 8N1", data_o, 8'hA5);
    check("R9 valid held", rx_valid_o, 1);
    check("R9 one done pulse", done_seen - d0, 1);
    read();
    check("R10 rd clears valid", rx_valid_o, 0);

    // R3: 5-bit frame masks upper bits
    frame(9'h0F5, 5, 0, 1'b1, 0);
    check("R3 data 5 bits", data_o, 8'h15);
    check("R4 bit9 zero short", bit9_o, 0);
    read();

    // R4 R5: 9 bits even parity
    par_en_i = 1'b1; par_odd_i = 1'b0;
    frame(9'h1C3, 9, 0, 1'b1, 0);
    check("R3 data 9 bits", data_o, 8'hC3);
    check("R4 ninth bit", bit9_o, 1);
    check("R5 parity ok", par_err_o, 0);
    read();

    // R5: 7 bits odd parity, corrupt parity bit
    par_odd_i = 1'b1;
    frame(9'h05A, 7, 1, 1'b1, 0);
    check("R5 parity error", par_err_o, 1);
    check("R3 data 7 bits", data_o, 8'h5A);
    read();
    frame(9'h05A, 7, 0, 1'b1, 0);
    check("R5 odd parity ok", par_err_o, 0);
    read();
    par_en_i = 1'b0;

    // R6: low stop bit
    frame(9'h03C, 8, 0, 1'b0, 0);
    check("R6 frame error", frame_err_o, 1);
    read();
    frame(9'h0C3, 8, 0, 1'b1, 0);
    check("R6 frame error clear", frame_err_o, 0);
    read();

    // R2 R7: double speed with noise
    dbl_i = 1'b1;
    frame(9'h02D, 6, 0, 1'b1, 1);
    check("R2 double speed data", data_o, 8'h2D);
    check("R7 noisy double", frame_err_o, 0);
    read();
    dbl_i = 1'b0;
    frame(9'h03C, 8, 0, 1'b1, 1);
    check("R7 noisy normal", data_o, 8'h3C);
    read();

    // R8: start glitch
    d0 = done_seen;
    for (int i = 0; i < 3; i++) samp(1'b0);
    for (int i = 0; i < 40; i++) samp(1'b1);
    check("R8 glitch ignored", rx_valid_o, 0);
    check("R8 no done on glitch", done_seen - d0, 0);
    frame(9'h081, 8, 0, 1'b1, 0);
    check("R8 frame after glitch", data_o, 8'h81);
    read();

    // R10: overrun
    frame(9'h011, 8, 0, 1'b1, 0);
    frame(9'h022, 8, 0, 1'b1, 0);
    check("R10 overrun flag", ovr_o, 1);
    check("R10 old data kept", data_o, 8'h11);
    read();
    check("R10 rd clears ovr", ovr_o, 0);
    check("R10 rd clears valid", rx_valid_o, 0);

    // R11: multi-drop filtering
    mpm_i = 1'b1;
    d0 = done_seen;
    frame(9'h0AA, 9, 0, 1'b1, 0);
    check("R11 data frame dropped", rx_valid_o, 0);
    check("R11 no done", done_seen - d0, 0);
    frame(9'h105, 9, 0, 1'b1, 0);
    check("R11 address accepted", data_o, 8'h05);
    check("R11 address bit", bit9_o, 1);
    read();
    frame(9'h066, 8, 0, 1'b0, 0);
    check("R11 low stop dropped", rx_valid_o, 0);
    frame(9'h077, 8, 0, 1'b1, 0);
    check("R11 short address", data_o, 8'h77);
    read();
    mpm_i = 1'b0;

    repeat (10) @(negedge clk_i);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule